// File: doc/BRIEF.md
# I2C Master Bit-Timing Engine

This block is the bit-level engine of a single-master I2C controller. It draws SCL and drives SDA as open-drain lines, with each line modelled as a pull-low enable. A host issues one command at a time: START, STOP, write a byte or read a byte. The engine then carries out the bus sequence with timing counted in system clocks and pulses a done flag when it finishes.

Every timed phase lasts H = 2^(N-1) system clocks, where N comes from a 3-bit divider code that is captured when the command is accepted. A full SCL period is therefore 2^N clocks with a 50% duty cycle. The engine moves SDA a fixed, short delay after it pulls SCL low, not at the middle of the low phase. It samples SDA at the last clock of each SCL high phase.

Top module: `i2c_bit_engine`

## Requirements
- R1: While reset is high and on the cycle after it, scl_oe, sda_oe, busy and done are all 0.
- R2: Command codes are 00 START, 01 STOP, 10 write byte and 11 read byte. START releases both lines for H clocks and then pulls SDA low while SCL stays released. It pulls SCL low H clocks later, and done pulses 2H clocks after acceptance.
- R3: H = 2^(N-1) with N = div_sel + 6 for codes 0 to 6. During a byte, each SCL released phase and each SCL pulled phase lasts exactly H clocks.
- R4: Code 7 runs with N = 12 and raises cfg_err. The next accepted command that carries a code from 0 to 6 clears cfg_err.
- R5: During a byte, sda_oe changes exactly DATA_DLY clocks (default 4) after scl_oe goes to 1. For the first bit, whose SCL is already low, the delay counts from command acceptance.
- R6: A write sends tx_byte MSB first, with a pulled SDA meaning 0. SDA is released for the ninth clock, and done pulses 18H clocks after acceptance.
- R7: After a byte, ack_bit holds the SDA level sampled at the end of the ninth SCL high phase, where 0 means acknowledged.
- R8: A read releases SDA for eight clocks and shifts the sampled levels MSB first into rx_byte. On the ninth clock it pulls SDA low unless send_nack is 1.
- R9: STOP pulls SCL low and pulls SDA low DATA_DLY clocks later. It releases SCL at H and releases SDA H clocks after that, and done pulses at 2H.
- R10: busy is high from acceptance until completion. A command presented while busy changes neither the running sequence's timing nor cfg_err.
- R11: done is a one-cycle pulse, and busy is already 0 in the cycle that done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd | input | 2 | Command code |
| div_sel | input | 3 | Divider code selecting N |
| tx_byte | input | 8 | Byte to write |
| send_nack | input | 1 | Read: 1 leaves the ninth clock released |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ack_bit | output | 1 | SDA level seen on the ninth clock |
| cfg_err | output | 1 | Reserved divider code in use |
| rx_byte | output | 8 | Byte shifted in from SDA |

## Verification
Directed bytes are chosen so that single changes and long runs on SDA are both present. For example, 0x80 gives one early change followed by a long run. These bytes show whether the launch delay is counted from the correct SCL edge and whether the bit order is reversed. Random bytes, random acknowledge answers from a modelled slave, and random choices between read and write at several divider codes separate a correct H for each code from a shifted exponent. The divider-code sweep includes codes 6 and 7, which tells the reserved-code mapping apart from the normal one. A command injected in the middle of a byte shows whether a busy engine really ignores its inputs.

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine #(
  parameter int DATA_DLY = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd,
  input  logic [2:0] div_sel,
  input  logic [7:0] tx_byte,
  input  logic       send_nack,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       busy,
  output logic       done,
  output logic       ack_bit,
  output logic       cfg_err,
  output logic [7:0] rx_byte
);
  localparam int CW = 12;

  typedef enum logic [2:0] {IDLE, STA_REL, STA_HOLD, BIT_LO, BIT_HI, STP_LO, STP_HI} phase_t;
  phase_t    ph;
  logic [2:0] sel_q;
  logic [CW-1:0] cnt;
  logic [3:0] idx;
  logic       rd_q, nack_q;
  logic [7:0] sh;

  wire [3:0]    n_exp   = (sel_q == 3'd7) ? 4'd12 : {1'b0, sel_q} + 4'd6;
  wire [CW-1:0] half_m1 = (CW'(1) << (n_exp - 4'd1)) - CW'(1);
  wire          last    = cnt == half_m1;
  wire          launch  = cnt == CW'(DATA_DLY - 1);

  assign busy    = ph != IDLE;
  assign cfg_err = sel_q == 3'd7;
  assign rx_byte = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= IDLE; scl_oe <= 1'b0; sda_oe <= 1'b0; done <= 1'b0; ack_bit <= 1'b0;
      cnt <= '0; idx <= '0; sel_q <= '0; rd_q <= 1'b0; nack_q <= 1'b0; sh <= '0;
    end else begin
      done <= 1'b0;
      cnt  <= cnt + CW'(1);
      case (ph)
        IDLE: if (cmd_valid) begin
          sel_q  <= div_sel;
          cnt    <= '0;
          idx    <= '0;
          rd_q   <= cmd == 2'b11;
          nack_q <= send_nack;
          case (cmd)
            2'b00: begin ph <= STA_REL; scl_oe <= 1'b0; sda_oe <= 1'b0; end
            2'b01: begin ph <= STP_LO; scl_oe <= 1'b1; end
            default: begin
              ph <= BIT_LO; scl_oe <= 1'b1;
              sh <= (cmd == 2'b10) ? tx_byte : 8'h00;
            end
          endcase
        end
        STA_REL: if (last) begin ph <= STA_HOLD; sda_oe <= 1'b1; cnt <= '0; end
        STA_HOLD: if (last) begin ph <= IDLE; scl_oe <= 1'b1; done <= 1'b1; end
        BIT_LO: begin
          if (launch)
            sda_oe <= (idx == 4'd8) ? (rd_q & ~nack_q) : (~rd_q & ~sh[7]);
          if (last) begin ph <= BIT_HI; scl_oe <= 1'b0; cnt <= '0; end
        end
        BIT_HI: if (last) begin
          scl_oe <= 1'b1;
          cnt    <= '0;
          if (idx == 4'd8) begin
            ph <= IDLE; ack_bit <= sda_in; done <= 1'b1;
          end else begin
            ph <= BIT_LO; sh <= {sh[6:0], sda_in}; idx <= idx + 4'd1;
          end
        end
        STP_LO: begin
          if (launch) sda_oe <= 1'b1;
          if (last) begin ph <= STP_HI; scl_oe <= 1'b0; cnt <= '0; end
        end
        STP_HI: if (last) begin ph <= IDLE; sda_oe <= 1'b0; done <= 1'b1; end
        default: ph <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_bit_engine_chk.sv
module i2c_bit_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       busy,
  input logic       done,
  input logic       cfg_err,
  input logic [2:0] sel_q
);
  logic        scl_q, busy_q, trk;
  logic [12:0] run;
  wire [3:0]  n_exp = (sel_q == 3'd7) ? 4'd12 : {1'b0, sel_q} + 4'd6;
  wire [12:0] half  = 13'd1 << (n_exp - 4'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b0; busy_q <= 1'b0; trk <= 1'b0; run <= '0;
    end else begin
      scl_q  <= scl_oe;
      busy_q <= busy;
      run    <= run + 13'd1;
      if (!scl_oe && scl_q) begin
        run <= 13'd1;
        trk <= busy_q;
      end else if (scl_oe && !scl_q) trk <= 1'b0;
      else if (!busy) trk <= 1'b0;
    end
  end

  AST_RESET_LINES: assert property (@(posedge clk) rst |=> (!scl_oe && !sda_oe && !busy && !done)); // R1
  AST_SCL_HIGH_HALF: assert property (@(posedge clk) disable iff (rst) (scl_oe && !scl_q && trk) |-> run == half); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) (!busy && !cmd_valid) |=> ($stable(scl_oe) && $stable(sda_oe))); // R10
  AST_CFG_HELD_BUSY: assert property (@(posedge clk) disable iff (rst) busy |=> $stable(cfg_err)); // R4
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> ($past(busy) && !busy)); // R11
endmodule

bind i2c_bit_engine i2c_bit_engine_chk u_chk (.*);

// File: tb/i2c_bit_engine_test.sv
`timescale 1ns/1ps
module i2c_bit_engine_test;
  localparam int DLY = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, send_nack = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [2:0] div_sel = 3'd0;
  logic [7:0] tx_byte = 8'h00;
  logic sda_in, scl_oe, sda_oe, busy, done, ack_bit, cfg_err;
  logic [7:0] rx_byte;

  int checks = 0, errors = 0, cyc = 0;
  int k = 9;
  bit in_byte = 0, rd_mode = 0, slv_ack = 0;
  logic [7:0] rbyte = 8'h00;
  logic slave_pull;

  int t_pull = 0, t_rel = 0, t_acc = 0, t_sda_pull = 0, t_sda_rel = 0;
  int last_hi = 0, last_lo = 0, n_launch = 0, bad_launch = 0;
  bit p_scl = 0, p_sda = 0, scl_at_sda_pull = 0;
  logic [8:0] obs = '0;

  always #4 clk = ~clk;

  assign slave_pull = in_byte && (rd_mode ? (k < 8 && !rbyte[7-k]) : (k == 8 && slv_ack));
  assign sda_in = !(sda_oe || slave_pull);

  i2c_bit_engine #(.DATA_DLY(DLY)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .div_sel(div_sel),
    .tx_byte(tx_byte), .send_nack(send_nack), .sda_in(sda_in), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .busy(busy), .done(done), .ack_bit(ack_bit), .cfg_err(cfg_err),
    .rx_byte(rx_byte));

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge scl_oe) k = k + 1;

  always @(negedge clk) begin
    if (in_byte && scl_oe && p_scl && sda_oe != p_sda) begin
      n_launch++;
      if (cyc - ((t_pull > t_acc) ? t_pull : t_acc) != DLY) bad_launch++;
    end
    if (scl_oe && !p_scl) begin t_pull = cyc; last_hi = cyc - t_rel; end
    if (!scl_oe && p_scl) begin t_rel = cyc; last_lo = cyc - t_pull; obs = {obs[7:0], !sda_oe}; end
    if (sda_oe && !p_sda) begin t_sda_pull = cyc; scl_at_sda_pull = scl_oe; end
    if (!sda_oe && p_sda) t_sda_rel = cyc;
    p_scl = scl_oe;
    p_sda = sda_oe;
  end

  function automatic int half_of(input logic [2:0] s);
    return (s == 3'd7) ? 2048 : (1 << (s + 5));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] c, input logic [2:0] s, input logic [7:0] b,
                         input logic nk, input bit inject, output int dur);
    int t0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; div_sel = s; tx_byte = b; send_nack = nk;
    k = 0; rd_mode = (c == 2'b11); in_byte = c[1];
    @(negedge clk);
    cmd_valid = 1'b0;
    t0 = cyc; t_acc = cyc;
    if (inject) begin
      repeat (40) @(negedge clk);
      cmd_valid = 1'b1; cmd = 2'b00; div_sel = 3'd7;
      @(negedge clk);
      cmd_valid = 1'b0; div_sel = s;
    end
    while (!done) @(negedge clk);
    dur = cyc - t0;
    chk("R11 busy low with done", busy, 0);
    @(negedge clk);
    chk("R11 done one cycle", done, 0);
    in_byte = 0;
  endtask

  task automatic do_byte(input bit rd, input logic [2:0] s, input logic [7:0] b,
                         input bit ack_or_nack, input bit inject);
    int d;
    int h = half_of(s);
    if (rd) begin
      rbyte = b;
      run_cmd(2'b11, s, 8'h00, ack_or_nack, 0, d);
      chk("R8 rx_byte", rx_byte, b);
      chk("R8 ninth clock drive", obs[0], ack_or_nack);
      chk("R7 ack_bit on read", ack_bit, ack_or_nack);
    end else begin
      slv_ack = ack_or_nack;
      run_cmd(2'b10, s, b, 1'b0, inject, d);
      chk("R6 bits on SDA MSB first", obs[8:1], b);
      chk("R6 SDA released on ninth", obs[0], 1);
      chk("R7 ack_bit on write", ack_bit, !ack_or_nack);
    end
    chk("R6 byte duration", d, 18 * h);
    chk("R3 SCL high time", last_hi, h);
    chk("R3 SCL low time", last_lo, h);
    if (inject) chk("R10 cfg_err kept while busy", cfg_err, 0);
  endtask

  task automatic do_start(input logic [2:0] s);
    int d;
    run_cmd(2'b00, s, 8'h00, 1'b0, 0, d);
    chk("R2 start duration", d, 2 * half_of(s));
    chk("R2 SDA falls with SCL released", scl_at_sda_pull, 0);
    chk("R2 SCL hold after SDA fall", t_pull - t_sda_pull, half_of(s));
  endtask

  task automatic do_stop(input logic [2:0] s);
    int d;
    run_cmd(2'b01, s, 8'h00, 1'b0, 0, d);
    chk("R9 stop duration", d, 2 * half_of(s));
    chk("R9 SDA rise after SCL release", t_sda_rel - t_rel, half_of(s));
    chk("R9 lines released", {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h1c2b);
    repeat (3) @(negedge clk);
    chk("R1 scl_oe in reset", scl_oe, 0);
    chk("R1 sda_oe in reset", sda_oe, 0);
    @(negedge clk); rst = 1'b0;
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);

    do_start(3'd0);
    do_byte(0, 3'd0, 8'h80, 1, 0);
    do_byte(1, 3'd0, 8'h5A, 1, 0);
    do_byte(1, 3'd0, 8'hA5, 0, 0);
    do_stop(3'd0);

    do_start(3'd7);
    chk("R4 reserved code flagged", cfg_err, 1);
    do_stop(3'd6);
    chk("R4 flag cleared by valid code", cfg_err, 0);

    do_start(3'd1);
    do_byte(0, 3'd1, 8'hC3, 1, 1);
    do_byte(0, 3'd4, 8'h01, 0, 0);
    do_stop(3'd2);

    for (int i = 0; i < 10; i++) begin
      logic [2:0] s;
      s = 3'($urandom_range(0, 3));
      do_start(s);
      do_byte(bit'($urandom_range(0, 1)), s, 8'($urandom), bit'($urandom_range(0, 1)), 0);
      do_stop(s);
    end

    chk("R5 data launch delay violations", bad_launch, 0);
    chk("R5 launches observed", n_launch > 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule